// File: doc/BRIEF.md
# Reciprocal Square Root Estimator

This unit takes one IEEE-754 single-precision operand and returns a coarse estimate of 1/sqrt(x) as a single-precision word. The estimate is bit-exact against a fixed table method, so it can seed a Newton-Raphson refinement done elsewhere. Operands that are not positive normal numbers are caught first and mapped to fixed answers. NaN inputs pass through unchanged.

For a positive normal operand, the parity of the exponent sets the scale of the mantissa. An odd exponent scales the mantissa into [0.25, 0.5) with 1/512 steps, and an even exponent scales it into [0.5, 1) with 1/256 steps. Only the seven fraction bits just under the hidden one choose the step. A constant table of 256 entries holds the 8-bit significand for each step and parity. The result exponent comes from a small subtractor.

The unit is fully pipelined. An operand goes in with a valid strobe and its result comes out two clocks later with a matching valid. The table read is registered so that it can map onto block RAM. A new operand can be accepted every cycle.

Top module: `rsqrt_est`

## Requirements
- R1: An operand whose exponent field is 255 with a zero fraction (either infinity), or whose exponent field is 253 or 254 (magnitude at least 2^126), of either sign, yields 0x00000000.
- R2: An operand whose exponent field is 0 (zero or subnormal, either sign) yields +infinity, 0x7F800000.
- R3: An operand whose exponent field is 255 with a nonzero fraction (NaN) is returned bit for bit.
- R4: A negative operand with exponent field 1 to 252 yields the quiet NaN 0x7FC00000.
- R5: For a positive operand with exponent field e in 1..252 and fraction f, let x = (1 + f/2^23)/4 when e is odd and (1 + f/2^23)/2 when e is even. Let q = floor(512x) when e is odd and floor(256x) when e is even. With the matching divisor D (512 or 256), let s = round-half-up(256 / sqrt((q+0.5)/D)), which lies in 256..511. The result fraction field (bits 22:0) is {s[7:0], 15'b0}.
- R6: For the same positive normal operands, result bit 31 is 0 and bits 30:23 hold floor((380 - e)/2).
- R7: out_valid rises exactly two clock edges after the edge that samples in_valid high, and out_res carries that operand's result in the same cycle. Back-to-back operands give back-to-back results in order.
- R8: While rst is high and after it is released, out_valid is 0 and out_res is 0 until the first result is due.
- R9: Operand bits 15:0 have no effect on the result of a positive normal operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result strobe, two cycles after in_valid |
| out_res | output | 32 | Single-precision estimate |

## Verification
Every result is due on the second rising edge after the edge that samples its operand. The valid flag must be low on the first edge when operands are sent one at a time. The bench drives on a falling edge and checks on the second falling edge after that. At that point both pipeline registers have settled, and no check depends on event order at a clock edge. In the burst test the bench checks the result of operand k-2 while it drives operand k, so two operands are in flight at once. A reference written with real arithmetic checks every table index under both exponent parities, every normal exponent, and each class of special operand.

// File: rtl/rsqrt_pkg.sv
package rsqrt_pkg;

  localparam int EXP_W      = 8;
  localparam int FRAC_W     = 23;
  localparam int WORD_W     = 1 + EXP_W + FRAC_W;
  localparam int LUT_FRAC_W = 7;
  localparam int LUT_ADDR_W = LUT_FRAC_W + 1;
  localparam int LUT_DEPTH  = 1 << LUT_ADDR_W;
  localparam int SIG_W      = 8;
  localparam int PAD_W      = FRAC_W - SIG_W;
  localparam int EXP_BIAS3  = 380;
  localparam int EXP_HUGE   = 253;

  localparam logic [WORD_W-1:0] POS_INF = 32'h7F80_0000;
  localparam logic [WORD_W-1:0] CAN_NAN = 32'h7FC0_0000;

  typedef enum logic [2:0] {
    CLS_NORM,
    CLS_ZERO,
    CLS_INF,
    CLS_PASS,
    CLS_QNAN
  } op_cls_e;

  // Rounded reciprocal root of the midpoint of table bin idx.
  // Bin midpoint in units of 1/D is (q + 0.5); s = round(256*sqrt(D/(q+0.5))).
  // s is the largest integer with (2s-1)^2 * (2q+1) <= 2^18 * 2 * D.
  function automatic logic [SIG_W-1:0] lut_entry(input int idx);
    longint den;
    longint lim;
    longint t;
    int     qv;
    bit     found;
    logic [SIG_W-1:0] res;
    res   = '0;
    found = 1'b0;
    qv    = (1 << LUT_FRAC_W) + (idx % (1 << LUT_FRAC_W));
    den   = longint'(2 * qv + 1);
    lim   = (idx >= (LUT_DEPTH / 2)) ? (longint'(1) <<< 28) : (longint'(1) <<< 27);
    for (int s = 511; s >= 256; s--) begin
      t = longint'(2 * s - 1);
      if (!found && (t * t * den <= lim)) begin
        res   = SIG_W'(s);
        found = 1'b1;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/rsqrt_classify.sv
module rsqrt_classify
  import rsqrt_pkg::*;
(
  input  logic [WORD_W-1:0]     op,
  output op_cls_e               cls,
  output logic [EXP_W-1:0]      res_exp,
  output logic [LUT_ADDR_W-1:0] lut_addr
);

  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic [EXP_W:0]    diff;

  assign sgn = op[WORD_W-1];
  assign ex  = op[WORD_W-2:FRAC_W];
  assign fr  = op[FRAC_W-1:0];

  always_comb begin
    if ((ex == '1) && (fr != '0))
      cls = CLS_PASS;
    else if (int'(ex) >= EXP_HUGE)
      cls = CLS_ZERO;
    else if (ex == '0)
      cls = CLS_INF;
    else if (sgn)
      cls = CLS_QNAN;
    else
      cls = CLS_NORM;
  end

  assign diff     = (EXP_W+1)'(EXP_BIAS3) - {1'b0, ex};
  assign res_exp  = diff[EXP_W:1];
  assign lut_addr = {ex[0], fr[FRAC_W-1 -: LUT_FRAC_W]};

endmodule

// File: rtl/rsqrt_rom.sv
module rsqrt_rom
  import rsqrt_pkg::*;
#(
  parameter int ADDR_W = LUT_ADDR_W,
  parameter int DATA_W = SIG_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DATA_W'(lut_entry(i));
  end

  always_ff @(posedge clk) begin
    if (rd_en) q <= mem[addr];
  end

endmodule

// File: rtl/rsqrt_est.sv
module rsqrt_est
  import rsqrt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] in_op,
  output logic        out_valid,
  output logic [31:0] out_res
);

  op_cls_e               cls_c;
  logic [EXP_W-1:0]      exp_c;
  logic [LUT_ADDR_W-1:0] addr_c;

  rsqrt_classify u_cls (
    .op      (in_op),
    .cls     (cls_c),
    .res_exp (exp_c),
    .lut_addr(addr_c)
  );

  logic [SIG_W-1:0] sig_q;

  rsqrt_rom #(
    .ADDR_W(LUT_ADDR_W),
    .DATA_W(SIG_W)
  ) u_rom (
    .clk  (clk),
    .rd_en(in_valid),
    .addr (addr_c),
    .q    (sig_q)
  );

  logic              v1;
  op_cls_e           cls1;
  logic [EXP_W-1:0]  exp1;
  logic [WORD_W-1:0] op1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1   <= 1'b0;
      cls1 <= CLS_ZERO;
      exp1 <= '0;
      op1  <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        cls1 <= cls_c;
        exp1 <= exp_c;
        op1  <= in_op;
      end
    end
  end

  logic [WORD_W-1:0] res_c;

  always_comb begin
    unique case (cls1)
      CLS_NORM: res_c = {1'b0, exp1, sig_q, {PAD_W{1'b0}}};
      CLS_INF:  res_c = POS_INF;
      CLS_QNAN: res_c = CAN_NAN;
      CLS_PASS: res_c = op1;
      default:  res_c = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_res   <= '0;
    end else begin
      out_valid <= v1;
      if (v1) out_res <= res_c;
    end
  end

endmodule

// File: rtl/rsqrt_est_chk.sv
module rsqrt_est_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [31:0] in_op,
  input logic        out_valid,
  input logic [31:0] out_res
);

  logic [1:0]  vd;
  logic [31:0] od0, od1;

  always_ff @(posedge clk) begin
    if (rst) begin
      vd  <= '0;
      od0 <= '0;
      od1 <= '0;
    end else begin
      vd  <= {vd[0], in_valid};
      od0 <= in_op;
      od1 <= od0;
    end
  end

  logic [7:0] e1;
  int         exp_ref;
  assign e1      = od1[30:23];
  assign exp_ref = (380 - int'(e1)) / 2;

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid == vd[1]); // R7
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!out_valid && out_res == 32'h0)); // R8
  AST_HUGE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (vd[1] && e1 >= 8'd253 && !(e1 == 8'hFF && od1[22:0] != 0)) |-> out_res == 32'h0); // R1
  AST_DENORM_INF: assert property (@(posedge clk) disable iff (rst)
    (vd[1] && e1 == 8'h00) |-> out_res == 32'h7F80_0000); // R2
  AST_NAN_PASS: assert property (@(posedge clk) disable iff (rst)
    (vd[1] && e1 == 8'hFF && od1[22:0] != 0) |-> out_res == od1); // R3
  AST_NEG_QNAN: assert property (@(posedge clk) disable iff (rst)
    (vd[1] && od1[31] && e1 != 0 && e1 < 8'd253) |-> out_res == 32'h7FC0_0000); // R4
  AST_NORM_EXP: assert property (@(posedge clk) disable iff (rst)
    (vd[1] && !od1[31] && e1 != 0 && e1 < 8'd253) |->
      (out_res[31:23] == {1'b0, exp_ref[7:0]} && out_res[14:0] == 15'h0)); // R6

endmodule

bind rsqrt_est rsqrt_est_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_op    (in_op),
  .out_valid(out_valid),
  .out_res  (out_res)
);

// File: tb/tb_rsqrt_est.sv
module tb_rsqrt_est;

  localparam real CLK_NS = 8.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_op = '0;
  logic        out_valid;
  logic [31:0] out_res;

  int checks = 0;
  int errors = 0;

  always #(CLK_NS / 2.0) clk = ~clk;

  rsqrt_est dut (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_op    (in_op),
    .out_valid(out_valid),
    .out_res  (out_res)
  );

  function automatic logic [31:0] model(input logic [31:0] a);
    int   e;
    int   q;
    int   s;
    int   ex;
    real  x;
    real  r;
    real  dv;
    e = int'(a[30:23]);
    if (e == 255 && a[22:0] != 0) return a;
    if (e >= 253) return 32'h0;
    if (e == 0) return 32'h7F80_0000;
    if (a[31]) return 32'h7FC0_0000;
    x  = (1.0 + real'(a[22:0]) / 8388608.0) * ((e % 2 == 1) ? 0.25 : 0.5);
    dv = (x < 0.5) ? 512.0 : 256.0;
    q  = $rtoi(x * dv);
    r  = 1.0 / $sqrt((real'(q) + 0.5) / dv);
    s  = $rtoi(256.0 * r + 0.5);
    ex = (380 - e) / 2;
    return {1'b0, ex[7:0], s[7:0], 15'h0};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic run_one(input logic [31:0] op, input string req);
    logic [31:0] want;
    want = model(op);
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = op;
    @(negedge clk);
    in_valid = 1'b0;
    in_op    = '0;
    check(out_valid == 1'b0, "R7 early valid", {31'h0, out_valid}, 32'h0);
    @(negedge clk);
    check(out_valid == 1'b1, "R7 valid", {31'h0, out_valid}, 32'h1);
    check(out_res == want, req, out_res, want);
  endtask

  initial begin
    #(CLK_NS * 150000.0);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [31:0] burst [8];
  logic [31:0] r9a, r9b;

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_res == 32'h0, "R8 in reset", out_res, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(out_valid == 1'b0 && out_res == 32'h0, "R8 after reset", out_res, 32'h0);

    // R5: every table index under both parities, low bits varied
    for (int i = 0; i < 256; i++) begin
      logic [7:0]  ex;
      logic [15:0] lo;
      ex = i[7] ? 8'd127 : 8'd126;
      lo = 16'(i * 40503 + 7);
      run_one({1'b0, ex, i[6:0], lo}, "R5 table index");
    end

    // R6: every normal exponent
    for (int e = 1; e <= 252; e++) begin
      logic [7:0] ev;
      ev = 8'(e);
      run_one({1'b0, ev, 23'(e * 33331)}, "R6 exponent");
    end

    // R1
    run_one(32'h7F80_0000, "R1 +inf");
    run_one(32'hFF80_0000, "R1 -inf");
    run_one(32'h7E80_0000, "R1 2^126");
    run_one(32'h7F7F_FFFF, "R1 max finite");
    run_one(32'hFEA1_2345, "R1 negative huge");
    // R2
    run_one(32'h0000_0000, "R2 +0");
    run_one(32'h8000_0000, "R2 -0");
    run_one(32'h0000_0001, "R2 subnormal");
    run_one(32'h807F_FFFF, "R2 negative subnormal");
    // R3
    run_one(32'h7FC0_0000, "R3 quiet NaN");
    run_one(32'h7F80_0001, "R3 signalling NaN");
    run_one(32'hFFD2_3456, "R3 negative NaN");
    // R4
    run_one(32'hBF80_0000, "R4 -1.0");
    run_one(32'h8080_0000, "R4 -min normal");
    run_one(32'hFE7F_FFFF, "R4 -just below huge");
    // R5/R6 edges
    run_one(32'h0080_0000, "R6 min normal");
    run_one(32'h7E7F_FFFF, "R6 largest accepted");
    run_one(32'h3F80_0000, "R5 1.0");
    run_one(32'h4080_0000, "R5 4.0");

    // R9: low operand bits ignored
    r9a = 32'h0;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_op    = (k == 0) ? 32'h3FD5_0000 : 32'h3FD5_FFFF;
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      if (k == 0) r9a = out_res;
      else r9b = out_res;
    end
    check(r9a == r9b && r9a == model(32'h3FD5_0000), "R9 low bits", r9b, r9a);

    // R7: back-to-back burst
    for (int i = 0; i < 8; i++) burst[i] = {1'b0, 8'(100 + i * 5), 23'(i * 1234567)};
    burst[3] = 32'h7FC0_1234;
    burst[5] = 32'h8000_0000;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        check(out_valid == 1'b1, "R7 burst valid", {31'h0, out_valid}, 32'h1);
        check(out_res == model(burst[k-2]), "R7 burst order", out_res, model(burst[k-2]));
      end
      in_valid = (k < 8);
      in_op    = (k < 8) ? burst[k] : 32'h0;
    end
    @(negedge clk);
    check(out_valid == 1'b0, "R7 burst end", {31'h0, out_valid}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule